// File: doc/BRIEF.md
# Vector Half Unpack and Widen Unit

This unit takes one packed vector of fixed width `VL` bits and returns a vector of the same width whose elements are twice as wide as those of the source. All result elements are drawn from one half of the source: either the lower `VL/2` bits or the upper `VL/2` bits. Each one is then widened to double width by sign extension or by zero extension.

Two control bits pick one of four variants: signed or unsigned, and low half or high half. A 2-bit size code, sampled with each operation, sets the element width. The datapath is combinational and ends in a single output register. An operation is accepted on every cycle that `valid_in` is high, and its result appears one clock later.

The output stage is a two-state machine. In `ST_EMPTY` no result is presented. In `ST_FULL` a result is presented. The transition `T_LOAD` goes to `ST_FULL` whenever `valid_in` is high, from either state. The transition `T_DRAIN` goes to `ST_EMPTY` whenever `valid_in` is low. The unit produces no condition flags of any kind.

Top module: `vec_unpack_widen`

## Requirements
- R1: `size_code` 01 gives 16-bit result elements built from 8-bit source elements. Code 10 gives 32-bit from 16-bit. Code 11 gives 64-bit from 32-bit. Element 0 occupies the least significant bits.
- R2: With `hi_sel`=0, result element e is built from source element e of the lower half (half-width element index e).
- R3: With `hi_sel`=1, result element e is built from half-width source element e+N, where N = VL / (result element width).
- R4: With `is_signed`=1, the upper half of each result element is a copy of the top bit of its source element.
- R5: With `is_signed`=0, the upper half of each result element is zero.
- R6: `size_code` 00 sets `illegal_size` to 1 and gives an all-zero result. Any other code clears `illegal_size`.
- R7: `valid_out` is high in exactly the cycle after a cycle with `valid_in` high. A new operation can be accepted on every cycle, and each result appears one cycle after it is accepted.
- R8: A synchronous, active-high `rst` clears `valid_out`, `result` and `illegal_size` to 0.
- R9: While `valid_in` is low, `result` and `illegal_size` keep their values and `valid_out` falls to 0.
- R10: Every result element is written on every accepted operation. No bit of the previous result survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operation accepted this cycle |
| src | input | VL | Packed source vector |
| hi_sel | input | 1 | 1 selects the upper half of the source, 0 the lower |
| is_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| size_code | input | 2 | Result element width code (see R1, R6) |
| valid_out | output | 1 | Result register holds a new result |
| result | output | VL | Widened vector |
| illegal_size | output | 1 | The last accepted size code was 00 |

## Verification
The assertions assume that every control input is at a known 0 or 1 level on each rising edge, and that `rst` is held for at least one edge before the first operation. The bench drives all inputs only on falling edges, from fully defined values. It holds reset for several cycles before the first operation. It sweeps all four size codes and all four variants over corner patterns and random vectors. It also inserts idle cycles whose inputs differ from those of the last operation, so that the hold behaviour is exercised with inputs that would otherwise change the result.

// File: rtl/vuw_pkg.sv
package vuw_pkg;

    typedef enum logic [1:0] {
        SZ_BAD = 2'b00,
        SZ_H16 = 2'b01,
        SZ_W32 = 2'b10,
        SZ_D64 = 2'b11
    } size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } out_st_e;

    localparam int unsigned NUM_WIDTHS = 3;

endpackage

// File: rtl/vuw_widen.sv
module vuw_widen #(
    parameter int unsigned VL = 256,
    parameter int unsigned DW = 16
) (
    input  logic [VL-1:0] src,
    input  logic          hi_sel,
    input  logic          is_signed,
    output logic [VL-1:0] wide
);
    localparam int unsigned SW = DW / 2;
    localparam int unsigned NE = VL / DW;
    localparam int unsigned HB = VL / 2;

    logic [HB-1:0] half;

    assign half = hi_sel ? src[VL-1:HB] : src[HB-1:0];

    for (genvar e = 0; e < NE; e++) begin : g_elem
        logic [SW-1:0] piece;
        logic          fill;
        assign piece = half[e*SW +: SW];
        assign fill  = is_signed & piece[SW-1];
        assign wide[e*DW +: DW] = {{SW{fill}}, piece};
    end

endmodule

// File: rtl/vuw_pick.sv
module vuw_pick
    import vuw_pkg::*;
#(
    parameter int unsigned VL = 256
) (
    input  logic [NUM_WIDTHS-1:0][VL-1:0] cand,
    input  logic [1:0]                    size_code,
    output logic [VL-1:0]                 picked,
    output logic                          bad
);
    size_e code;

    assign code = size_e'(size_code);

    always_comb begin
        picked = '0;
        bad    = 1'b0;
        unique case (code)
            SZ_H16: picked = cand[0];
            SZ_W32: picked = cand[1];
            SZ_D64: picked = cand[2];
            SZ_BAD: bad    = 1'b1;
            default: bad   = 1'b1;
        endcase
    end

endmodule

// File: rtl/vuw_outreg.sv
module vuw_outreg
    import vuw_pkg::*;
#(
    parameter int unsigned VL = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_in,
    input  logic [VL-1:0] next_res,
    input  logic          next_bad,
    output logic          valid_out,
    output logic [VL-1:0] result,
    output logic          illegal_size
);
    out_st_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: state_nx = valid_in ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = valid_in ? ST_FULL : ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            illegal_size <= 1'b0;
        end else if (valid_in) begin
            result       <= next_res;
            illegal_size <= next_bad;
        end
    end

    assign valid_out = (state == ST_FULL);

endmodule

// File: rtl/vec_unpack_widen.sv
module vec_unpack_widen
    import vuw_pkg::*;
#(
    parameter int unsigned VL = 256
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_in,
    input  logic [VL-1:0] src,
    input  logic          hi_sel,
    input  logic          is_signed,
    input  logic [1:0]    size_code,
    output logic          valid_out,
    output logic [VL-1:0] result,
    output logic          illegal_size
);
    if (VL % 64 != 0 || VL == 0) begin : g_bad_vl
        $error("VL must be a nonzero multiple of 64");
    end

    logic [NUM_WIDTHS-1:0][VL-1:0] cand;
    logic [VL-1:0]                 picked;
    logic                          bad;

    for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
        vuw_widen #(.VL(VL), .DW(16 << g)) u_widen (
            .src       (src),
            .hi_sel    (hi_sel),
            .is_signed (is_signed),
            .wide      (cand[g])
        );
    end

    vuw_pick #(.VL(VL)) u_pick (
        .cand      (cand),
        .size_code (size_code),
        .picked    (picked),
        .bad       (bad)
    );

    vuw_outreg #(.VL(VL)) u_out (
        .clk          (clk),
        .rst          (rst),
        .valid_in     (valid_in),
        .next_res     (picked),
        .next_bad     (bad),
        .valid_out    (valid_out),
        .result       (result),
        .illegal_size (illegal_size)
    );

endmodule

// File: rtl/vuw_chk.sv
module vuw_chk #(
    parameter int unsigned VL = 256
) (
    input logic          clk,
    input logic          rst,
    input logic          valid_in,
    input logic [VL-1:0] src,
    input logic          hi_sel,
    input logic          is_signed,
    input logic [1:0]    size_code,
    input logic          valid_out,
    input logic [VL-1:0] result,
    input logic          illegal_size
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out); // R7

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out); // R9

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(result) && $stable(illegal_size))); // R9

    AST_BAD_CODE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (valid_in && size_code == 2'b00) |=> illegal_size); // R6

    AST_BAD_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        illegal_size |-> (result == '0)); // R6

    AST_GOOD_CODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (valid_in && size_code != 2'b00) |=> !illegal_size); // R6

    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (valid_in && size_code == 2'b11 && is_signed && !hi_sel)
        |=> (result[63:32] == {32{$past(src[31])}})); // R4

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (valid_in && size_code == 2'b01 && !is_signed)
        |=> (result[15:8] == 8'h00)); // R5

    AST_HIGH_PICK: assert property (@(posedge clk) disable iff (rst)
        (valid_in && size_code == 2'b11 && hi_sel)
        |=> (result[31:0] == $past(src[VL/2 +: 32]))); // R3

endmodule

bind vec_unpack_widen vuw_chk #(.VL(VL)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .valid_in     (valid_in),
    .src          (src),
    .hi_sel       (hi_sel),
    .is_signed    (is_signed),
    .size_code    (size_code),
    .valid_out    (valid_out),
    .result       (result),
    .illegal_size (illegal_size)
);

// File: tb/tb_vec_unpack_widen.sv
`timescale 1ns/1ps
module tb_vec_unpack_widen;
    localparam int VL = 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_in = 1'b0;
    logic [VL-1:0] src = '0;
    logic          hi_sel = 1'b0;
    logic          is_signed = 1'b0;
    logic [1:0]    size_code = 2'b00;
    logic          valid_out;
    logic [VL-1:0] result;
    logic          illegal_size;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    vec_unpack_widen #(.VL(VL)) dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .src(src),
        .hi_sel(hi_sel), .is_signed(is_signed), .size_code(size_code),
        .valid_out(valid_out), .result(result), .illegal_size(illegal_size)
    );

    function automatic logic [VL-1:0] model(logic [VL-1:0] s, logic hi,
                                            logic sg, logic [1:0] sz);
        logic [VL-1:0] r = '0;
        int dw, sw, n, base;
        if (sz == 2'b00) return r;
        dw = 8 << sz;
        sw = dw / 2;
        n  = VL / dw;
        for (int e = 0; e < n; e++) begin
            base = (hi ? e + n : e) * sw;
            for (int b = 0; b < dw; b++) begin
                if (b < sw) r[e*dw + b] = s[base + b];
                else        r[e*dw + b] = sg ? s[base + sw - 1] : 1'b0;
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic [VL-1:0] act, logic [VL-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic [VL-1:0] last_exp = '0;
    logic          last_bad = 1'b0;

    // Drive one op at a falling edge; the result is checked at the next falling edge.
    task automatic run_op(logic [VL-1:0] s, logic hi, logic sg, logic [1:0] sz);
        string tag;
        logic [VL-1:0] exp;
        exp = model(s, hi, sg, sz);
        src = s; hi_sel = hi; is_signed = sg; size_code = sz; valid_in = 1'b1;
        @(negedge clk);
        if (sz == 2'b00) tag = "R6";
        else tag = $sformatf("R1/%s/%s/R10 sz=%0d", hi ? "R3" : "R2", sg ? "R4" : "R5", sz);
        check(tag, result, exp);
        check("R6 flag", {255'b0, illegal_size}, {255'b0, sz == 2'b00});
        check("R7 valid", {255'b0, valid_out}, {255'b0, 1'b1});
        last_exp = exp;
        last_bad = (sz == 2'b00);
    endtask

    task automatic idle_cycle();
        valid_in = 1'b0;
        src = ~src; hi_sel = ~hi_sel; is_signed = ~is_signed; size_code = size_code + 2'd1;
        @(negedge clk);
        check("R9 hold result", result, last_exp);
        check("R9 hold flag", {255'b0, illegal_size}, {255'b0, last_bad});
        check("R9 valid low", {255'b0, valid_out}, 256'b0);
    endtask

    function automatic logic [VL-1:0] pattern(int p, int sz);
        logic [VL-1:0] v = '0;
        int sw = (sz == 0) ? 8 : (4 << sz);
        case (p)
            0: for (int i = 0; i < VL / sw; i++) v[i*sw + sw - 1] = 1'b1; // most negative
            1: v = '1;
            2: for (int i = 0; i < VL / sw; i++) v[i*sw +: 8] = 8'h7F;
            3: for (int i = 0; i < VL / 2; i++) v[i] = 1'b1; // low half ones, high half zero
            default: for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        endcase
        return v;
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        check("R8 reset result", result, '0);
        check("R8 reset flag", {255'b0, illegal_size}, 256'b0);
        check("R8 reset valid", {255'b0, valid_out}, 256'b0);
        rst = 1'b0;
        for (int sz = 0; sz < 4; sz++) begin
            for (int v = 0; v < 4; v++) begin
                for (int p = 0; p < 7; p++) begin
                    run_op(pattern(p, sz), v[1], v[0], 2'(sz));
                end
                idle_cycle();
            end
        end
        // back-to-back ops alternating sizes and variants (throughput)
        for (int k = 0; k < 40; k++) begin
            run_op(pattern(5, 0), k[0], k[1], 2'(k % 4));
        end
        idle_cycle();
        // reset mid-stream
        valid_in = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset result late", result, '0);
        check("R8 reset valid late", {255'b0, valid_out}, 256'b0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog act=timeout exp=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule